// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block sits in an always-on domain and sequences a system through a powered-down period. Software writes a one to the sleep command register; the block then drops its power-enable output and waits. An active-low wakeup pin is debounced against a programmed number of slow-clock ticks. Once the pin has been held low long enough, power is restored. The system reset output is then held low for a second programmed tick count and released. Slow-clock ticks arrive as a one-cycle strobe in the block's own clock domain. Both durations are held at a granularity of 32 ticks. The low five bits of each duration register are not stored.

The controller has four states. RUN is the reset state: power is on and reset is released. RUN goes to SLEEP on a sleep command write. SLEEP goes to DEBOUNCE when the pin is seen low. DEBOUNCE goes back to SLEEP if the pin rises, and goes to HOLD when the tick count reaches the debounce limit. HOLD goes to RUN when the tick count reaches the hold limit. Power is off in SLEEP and DEBOUNCE. Reset is driven low only in HOLD. Each debounce attempt starts counting from zero.

Register map (word offsets): sleep command 0x20, debounce limit 0x24, hold limit 0x28. Reads of any other offset return zero.

Top module: `hws_sequencer`

## Requirements
- R1: After reset the block is in RUN with pwr_en=1 and rst_out_n=1. The debounce limit and hold limit registers both read 0.
- R2: A write to offset 0x20 with wdata bit 0 set, made while in RUN, drives pwr_en low from the next cycle. Such a write with bit 0 clear, or made in any other state, has no effect. Offset 0x20 reads 0.
- R3: The debounce limit at offset 0x24 stores wdata bits 15:5. All other bits read zero.
- R4: The hold limit at offset 0x28 stores wdata bits 11:5. All other bits read zero. Any offset other than 0x20, 0x24 and 0x28 reads zero.
- R5: In SLEEP, a low on wake_n moves the block to DEBOUNCE. DEBOUNCE counts tick_en strobes while wake_n stays low. When the count is at least the debounce limit, the block enters HOLD and pwr_en rises on the next cycle.
- R6: A high on wake_n in DEBOUNCE returns the block to SLEEP. The count restarts from zero on the next attempt.
- R7: If wake_n goes high in the same cycle in which the count first meets the debounce limit, the wakeup is rejected. The block returns to SLEEP with pwr_en still low.
- R8: In HOLD, rst_out_n stays low while tick_en strobes are counted up to the hold limit. rst_out_n then rises with pwr_en high, and the block is back in RUN.
- R9: pwr_en is low exactly in SLEEP and DEBOUNCE. rst_out_n is low only in HOLD, so reset is never asserted while power is off.
- R10: With a debounce limit of 0, a wake_n low lasting two cycles is accepted. With a hold limit of 0, HOLD lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe per slow-clock tick |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wake_n | input | 1 | Active-low wakeup pin, already in clk domain |
| pwr_en | output | 1 | Power enable for the switched domain |
| rst_out_n | output | 1 | Active-low system reset |

## Verification
The critical collision is a pin release that lands in the very cycle in which the debounce count first meets its limit. Here the abort path and the accept path compete. The bench follows its own behavioural model of the count. It raises wake_n just after the count reaches the limit, so the next edge sees both conditions at once. It then checks that power stays off and that the sequencer has fallen back to sleep. The same collision is provoked with a zero limit, where the limit is met on the first debounce cycle. Tick strobes meeting a threshold in the same cycle are covered by the per-cycle model comparison.

// File: rtl/hws_pkg.sv
package hws_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_DEB   = 2'd2,
        ST_HOLD  = 2'd3
    } hws_state_e;

    localparam logic [7:0] OFS_SLEEP = 8'h20;
    localparam logic [7:0] OFS_DEB   = 8'h24;
    localparam logic [7:0] OFS_HOLD  = 8'h28;

endpackage

// File: rtl/hws_regs.sv
module hws_regs #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int DEB_MSB  = 15,
    parameter int HOLD_MSB = 11,
    parameter int GRAN_LSB = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sleep_req,
    output logic [DEB_MSB:0]  deb_lim,
    output logic [HOLD_MSB:0] hold_lim
);
    import hws_pkg::*;

    localparam int DEB_W  = DEB_MSB - GRAN_LSB + 1;
    localparam int HOLD_W = HOLD_MSB - GRAN_LSB + 1;

    logic [DEB_W-1:0]  deb_q;
    logic [HOLD_W-1:0] hold_q;
    logic              hit_sleep, hit_deb, hit_hold;
    logic              wdata_unused;

    assign hit_sleep = (bus_addr == ADDR_W'(OFS_SLEEP));
    assign hit_deb   = (bus_addr == ADDR_W'(OFS_DEB));
    assign hit_hold  = (bus_addr == ADDR_W'(OFS_HOLD));

    assign wdata_unused = ^{bus_wdata[DATA_W-1:DEB_MSB+1], bus_wdata[GRAN_LSB-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deb_q  <= '0;
            hold_q <= '0;
        end else if (bus_sel && bus_wr) begin
            if (hit_deb)  deb_q  <= bus_wdata[DEB_MSB:GRAN_LSB];
            if (hit_hold) hold_q <= bus_wdata[HOLD_MSB:GRAN_LSB];
        end
    end

    assign sleep_req = bus_sel && bus_wr && hit_sleep && bus_wdata[0];
    assign deb_lim   = {deb_q, {GRAN_LSB{1'b0}}};
    assign hold_lim  = {hold_q, {GRAN_LSB{1'b0}}};

    always_comb begin
        bus_rdata = '0;
        if (hit_deb)  bus_rdata[DEB_MSB:0]  = deb_lim;
        if (hit_hold) bus_rdata[HOLD_MSB:0] = hold_lim;
    end

    // R3
    deb_rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_deb |-> (bus_rdata[GRAN_LSB-1:0] == '0 && bus_rdata[DATA_W-1:DEB_MSB+1] == '0));

    // R4
    hold_rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_hold |-> (bus_rdata[GRAN_LSB-1:0] == '0 && bus_rdata[DATA_W-1:HOLD_MSB+1] == '0));

    // R2
    sleep_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_sleep |-> (bus_rdata == '0));

endmodule

// File: rtl/hws_count.sv
module hws_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    // R6
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/hws_fsm.sv
module hws_fsm #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             wake_n,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] deb_lim,
    input  logic [CNT_W-1:0] hold_lim,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             pwr_en,
    output logic             rst_out_n
);
    import hws_pkg::*;

    hws_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                cnt_clr = 1'b1;
                if (sleep_req) state_d = ST_SLEEP;
            end
            ST_SLEEP: begin
                cnt_clr = 1'b1;
                if (!wake_n) state_d = ST_DEB;
            end
            ST_DEB: begin
                if (wake_n) begin
                    state_d = ST_SLEEP;
                    cnt_clr = 1'b1;
                end else if (cnt >= deb_lim) begin
                    state_d = ST_HOLD;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = tick_en;
                end
            end
            ST_HOLD: begin
                if (cnt >= hold_lim) begin
                    state_d = ST_RUN;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = tick_en;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        pwr_en    = 1'b1;
        rst_out_n = 1'b1;
        unique case (state_q)
            ST_RUN:   ;
            ST_SLEEP: pwr_en = 1'b0;
            ST_DEB:   pwr_en = 1'b0;
            ST_HOLD:  rst_out_n = 1'b0;
            default:  ;
        endcase
    end

    // R9
    off_implies_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> rst_out_n);

    // R2
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && rst_out_n && sleep_req) |=> !pwr_en);

    // R6
    deb_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEB && wake_n) |=> (state_q == ST_SLEEP && !pwr_en));

    // R8
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> pwr_en);

endmodule

// File: rtl/hws_sequencer.sv
module hws_sequencer #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int DEB_MSB  = 15,
    parameter int HOLD_MSB = 11,
    parameter int GRAN_LSB = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wake_n,
    output logic              pwr_en,
    output logic              rst_out_n
);

    localparam int CNT_W = DEB_MSB + 1;

    logic              sleep_req;
    logic [DEB_MSB:0]  deb_lim;
    logic [HOLD_MSB:0] hold_lim;
    logic [CNT_W-1:0]  hold_lim_ext;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_clr, cnt_inc;

    assign hold_lim_ext = CNT_W'(hold_lim);

    hws_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEB_MSB(DEB_MSB),
        .HOLD_MSB(HOLD_MSB), .GRAN_LSB(GRAN_LSB)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sleep_req(sleep_req), .deb_lim(deb_lim), .hold_lim(hold_lim)
    );

    hws_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
    );

    hws_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_n(wake_n),
        .tick_en(tick_en), .deb_lim(deb_lim), .hold_lim(hold_lim_ext),
        .cnt(cnt), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
        .pwr_en(pwr_en), .rst_out_n(rst_out_n)
    );

endmodule

// File: tb/test_hws_sequencer.sv
`timescale 1ns/1ps
module test_hws_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        wake_n = 1'b1;
    logic        pwr_en;
    logic        rst_out_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model
    int m_state = 0;   // 0 run, 1 sleep, 2 debounce, 3 hold
    int m_cnt = 0;
    int m_deb = 0;
    int m_hold = 0;

    always #4 clk = ~clk;

    hws_sequencer i_hws_sequencer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wake_n(wake_n), .pwr_en(pwr_en),
        .rst_out_n(rst_out_n)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_rdata(input int addr);
        if (addr == 'h24) return m_deb;
        if (addr == 'h28) return m_hold;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_deb = 0; m_hold = 0;
        end else begin
            case (m_state)
                0: begin
                    m_cnt = 0;
                    if (bus_sel && bus_wr && bus_addr == 8'h20 && bus_wdata[0]) m_state = 1;
                end
                1: begin
                    m_cnt = 0;
                    if (!wake_n) m_state = 2;
                end
                2: begin
                    if (wake_n) begin m_state = 1; m_cnt = 0; end
                    else if (m_cnt >= m_deb) begin m_state = 3; m_cnt = 0; end
                    else if (tick_en) m_cnt++;
                end
                default: begin
                    if (m_cnt >= m_hold) begin m_state = 0; m_cnt = 0; end
                    else if (tick_en) m_cnt++;
                end
            endcase
            if (bus_sel && bus_wr && bus_addr == 8'h24) m_deb = int'(bus_wdata & 32'h0000FFE0);
            if (bus_sel && bus_wr && bus_addr == 8'h28) m_hold = int'(bus_wdata & 32'h00000FE0);
        end
    end

    // per-cycle comparison, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R9 pwr_en", pwr_en, (m_state == 1 || m_state == 2) ? 0 : 1);
            check("R8 rst_out_n", rst_out_n, (m_state == 3) ? 0 : 1);
            check("R4 rdata", bus_rdata, model_rdata(int'(bus_addr)));
        end
    end

    // slow tick: one strobe every third cycle
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk); #1;
            ph = (ph + 1) % 3;
            tick_en = (ph == 0);
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 32'h0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
        check(req, bus_rdata, exp);
        @(negedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic wait_state(input int st);
        for (int i = 0; i < 5000; i++) begin
            if (m_state == st) break;
            @(negedge clk); #1;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog R5 actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        check("R1 pwr_en", pwr_en, 1);
        check("R1 rst_out_n", rst_out_n, 1);
        bus_read(8'h24, 32'h0, "R1 deb reg");
        bus_read(8'h28, 32'h0, "R1 hold reg");

        // R3 / R4 implemented bits
        bus_write(8'h24, 32'hFFFF_FFFF);
        bus_read(8'h24, 32'h0000_FFE0, "R3 deb mask");
        bus_write(8'h28, 32'hFFFF_FFFF);
        bus_read(8'h28, 32'h0000_0FE0, "R4 hold mask");
        bus_read(8'h20, 32'h0, "R2 sleep reads zero");
        bus_read(8'h2C, 32'h0, "R4 unmapped reads zero");

        bus_write(8'h24, 32'h0000_0040);
        bus_write(8'h28, 32'h0000_0020);

        // R2 write with bit 0 clear is ignored
        bus_write(8'h20, 32'h0000_0002);
        idle(1);
        check("R2 ignored write", pwr_en, 1);

        // R2 enter sleep
        bus_write(8'h20, 32'h1);
        check("R2 sleep entry", pwr_en, 0);
        bus_write(8'h20, 32'h1);
        check("R2 write while asleep", pwr_en, 0);

        // R6 short glitch rejected
        wake_n = 1'b0;
        idle(40);
        wake_n = 1'b1;
        idle(3);
        check("R6 glitch rejected", pwr_en, 0);

        // R5 held low long enough
        wake_n = 1'b0;
        wait_state(3);
        wake_n = 1'b1;
        idle(1);
        check("R5 power restored", pwr_en, 1);
        check("R8 reset held", rst_out_n, 0);
        wait_state(0);
        idle(1);
        check("R8 reset released", rst_out_n, 1);

        // R7 release in the cycle the count meets the limit
        bus_write(8'h24, 32'h0000_0020);
        bus_write(8'h20, 32'h1);
        wake_n = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (m_state == 2 && m_cnt == 32) break;
            @(negedge clk); #1;
        end
        wake_n = 1'b1;
        idle(1);
        check("R7 collision rejected", pwr_en, 0);
        idle(4);
        check("R7 still asleep", pwr_en, 0);

        wake_n = 1'b0;
        wait_state(0);
        wake_n = 1'b1;
        idle(2);
        check("R8 back in run", pwr_en & rst_out_n, 1);

        // R10 zero limits
        bus_write(8'h24, 32'h0000_001F);
        bus_write(8'h28, 32'h0);
        bus_write(8'h20, 32'h1);
        // one-cycle low: meets zero limit and release together, rejected
        wake_n = 1'b0;
        idle(1);
        wake_n = 1'b1;
        idle(3);
        check("R7 zero limit collision", pwr_en, 0);
        wake_n = 1'b0;
        idle(2);
        wake_n = 1'b1;
        check("R10 zero deb hold low", rst_out_n, 0);
        idle(1);
        check("R10 zero hold single cycle", rst_out_n, 1);
        check("R10 powered", pwr_en, 1);
        idle(5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule